// File: doc/BRIEF.md
# Single-Bit Manipulation Execution Unit

This unit executes the single-bit group of a core's integer operations: it clears, sets or flips one chosen bit of a source operand, or pulls that bit out as a zero-extended value. The bit position comes from the low bits of a second register operand or from a 6-bit immediate field. The datapath width `XLEN` is a parameter and must be 32 or 64. Both widths use the same semantics.

A decode stage upstream presents one operation per cycle with a valid strobe. The unit returns the result and a valid flag one clock later. The index is always taken modulo `XLEN`, so the upper index bits are dropped and no operand value is ever treated as an error. On a 32-bit datapath, an immediate whose bit 5 is set is a reserved encoding. The unit raises a flag beside the result in that case. It still returns a result, computed from the low five immediate bits.

Top module: `sbit_unit`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `res_valid`, `res_data` and `res_rsvd` to zero.
- R2: `res_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: With `op` = 2'b00 (clear), the result is `src_a` with the indexed bit forced to 0 and every other bit unchanged.
- R4: With `op` = 2'b01 (set), the result is `src_a` with the indexed bit forced to 1 and every other bit unchanged.
- R5: With `op` = 2'b10 (invert), the result is `src_a` with the indexed bit complemented and every other bit unchanged.
- R6: With `op` = 2'b11 (extract), result bit 0 equals the indexed bit of `src_a`, and bits XLEN-1 down to 1 are zero.
- R7: With `use_imm` = 0, the index is `src_b` modulo XLEN, that is `src_b` bits log2(XLEN)-1 down to 0. The higher bits of `src_b` and all bits of `imm_sh` have no effect on the result.
- R8: With `use_imm` = 1, the index is `imm_sh` modulo XLEN, and `src_b` has no effect on the result.
- R9: `res_rsvd` is high exactly when `res_valid` is high and the operation it reports had `use_imm` = 1, `imm_sh[5]` = 1 and XLEN = 32. The result is still produced in that case.
- R10: In a cycle following one with `in_valid` low, `res_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 2 | 00 clear, 01 set, 10 invert, 11 extract |
| use_imm | input | 1 | 1: the index comes from `imm_sh`; 0: from `src_b` |
| src_a | input | XLEN | Operand whose bit is modified or read |
| src_b | input | XLEN | Register index source |
| imm_sh | input | 6 | Immediate index field |
| res_valid | output | 1 | `res_data` holds a new result |
| res_data | output | XLEN | Registered result |
| res_rsvd | output | 1 | The reported operation was a reserved immediate encoding |

## Verification
Each result, together with its reserved flag, is due at the first rising edge after the cycle in which the operation is presented. The driver applies an operation on a falling edge and pushes the expected value into a queue. The monitor samples 2 ns after every rising edge and pops one entry whenever `res_valid` is high, which puts every comparison exactly one edge after its stimulus. Idle cycles are checked at the same sampling point: the valid flag must be low and the data unchanged, and the queue must be empty at the end.

// File: rtl/sbit_pkg.sv
package sbit_pkg;

  typedef enum logic [1:0] {
    SB_CLR = 2'b00,
    SB_SET = 2'b01,
    SB_INV = 2'b10,
    SB_EXT = 2'b11
  } sb_op_e;

  localparam int unsigned SB_IMM_W = 6;

  // An immediate index is reserved when it cannot address a bit of the datapath.
  function automatic logic sb_imm_reserved(input int unsigned xlen,
                                           input logic use_imm,
                                           input logic [SB_IMM_W-1:0] imm);
    return use_imm && (xlen == 32) && imm[SB_IMM_W-1];
  endfunction

endpackage

// File: rtl/sbit_idx_sel.sv
module sbit_idx_sel
  import sbit_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned IDXW = $clog2(XLEN)
) (
  input  logic                 use_imm,
  input  logic [XLEN-1:0]      src_b,
  input  logic [SB_IMM_W-1:0]  imm_sh,
  output logic [IDXW-1:0]      idx,
  output logic                 imm_rsvd
);

  // Taking only the low bits is the modulo-XLEN reduction.
  always_comb begin
    if (use_imm) idx = imm_sh[IDXW-1:0];
    else         idx = src_b[IDXW-1:0];
  end

  assign imm_rsvd = sb_imm_reserved(XLEN, use_imm, imm_sh);

endmodule

// File: rtl/sbit_mask_dec.sv
module sbit_mask_dec #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned IDXW = $clog2(XLEN)
) (
  input  logic [IDXW-1:0] idx,
  output logic [XLEN-1:0] mask
);

  // One comparator per bit position instead of a barrel shifter.
  for (genvar g = 0; g < XLEN; g++) begin : g_dec
    assign mask[g] = (idx == IDXW'(g));
  end

endmodule

// File: rtl/sbit_op_core.sv
module sbit_op_core
  import sbit_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  sb_op_e          op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] mask,
  output logic [XLEN-1:0] result
);

  function automatic logic [XLEN-1:0] apply_op(input sb_op_e o,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] m);
    logic [XLEN-1:0] r;
    unique case (o)
      SB_CLR:  r = a & ~m;
      SB_SET:  r = a | m;
      SB_INV:  r = a ^ m;
      default: r = {{(XLEN-1){1'b0}}, |(a & m)};
    endcase
    return r;
  endfunction

  assign result = apply_op(op, src_a, mask);

endmodule

// File: rtl/sbit_out_reg.sv
module sbit_out_reg #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] d,
  input  logic            rsvd,
  output logic            q_valid,
  output logic [XLEN-1:0] q,
  output logic            q_rsvd
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
      q_rsvd  <= 1'b0;
    end else begin
      q_valid <= in_valid;
      q_rsvd  <= in_valid & rsvd;
      if (in_valid) q <= d;
    end
  end

endmodule

// File: rtl/sbit_unit.sv
module sbit_unit
  import sbit_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [1:0]          op,
  input  logic                use_imm,
  input  logic [XLEN-1:0]     src_a,
  input  logic [XLEN-1:0]     src_b,
  input  logic [SB_IMM_W-1:0] imm_sh,
  output logic                res_valid,
  output logic [XLEN-1:0]     res_data,
  output logic                res_rsvd
);

  localparam int unsigned IDXW = $clog2(XLEN);

  logic [IDXW-1:0] bit_idx;
  logic [XLEN-1:0] bit_mask;
  logic [XLEN-1:0] op_result;
  logic            imm_rsvd;

  sbit_idx_sel #(.XLEN(XLEN)) u_idx (
    .use_imm (use_imm),
    .src_b   (src_b),
    .imm_sh  (imm_sh),
    .idx     (bit_idx),
    .imm_rsvd(imm_rsvd)
  );

  sbit_mask_dec #(.XLEN(XLEN)) u_dec (
    .idx (bit_idx),
    .mask(bit_mask)
  );

  sbit_op_core #(.XLEN(XLEN)) u_core (
    .op    (sb_op_e'(op)),
    .src_a (src_a),
    .mask  (bit_mask),
    .result(op_result)
  );

  sbit_out_reg #(.XLEN(XLEN)) u_out (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .d       (op_result),
    .rsvd    (imm_rsvd),
    .q_valid (res_valid),
    .q       (res_data),
    .q_rsvd  (res_rsvd)
  );

endmodule

// File: rtl/sbit_unit_chk.sv
module sbit_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      op,
  input logic            use_imm,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] bit_mask,
  input logic            res_valid,
  input logic [XLEN-1:0] res_data,
  input logic            res_rsvd
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!res_valid && !res_rsvd && res_data == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  assert_clear_no_new_ones_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b00) |=> ((res_data & ~$past(src_a)) == '0));

  assert_set_no_lost_ones_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01) |=> (($past(src_a) & ~res_data) == '0));

  assert_invert_one_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b10) |=> ($countones(res_data ^ $past(src_a)) == 1));

  assert_extract_zero_ext_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b11) |=> (res_data[XLEN-1:1] == '0));

  assert_one_hot_index_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ($countones(bit_mask) == 1));

  assert_rsvd_with_valid_R9: assert property (@(posedge clk) disable iff (rst)
    res_rsvd |-> res_valid);

  assert_rsvd_reg_form_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !use_imm) |=> !res_rsvd);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_data));

endmodule

bind sbit_unit sbit_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op       (op),
  .use_imm  (use_imm),
  .src_a    (src_a),
  .bit_mask (bit_mask),
  .res_valid(res_valid),
  .res_data (res_data),
  .res_rsvd (res_rsvd)
);

// File: tb/sbit_unit_test.sv
module sbit_unit_test;

  localparam int unsigned XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [1:0]      op = 2'b00;
  logic            use_imm = 1'b0;
  logic [XLEN-1:0] src_a = '0;
  logic [XLEN-1:0] src_b = '0;
  logic [5:0]      imm_sh = '0;
  logic            res_valid;
  logic [XLEN-1:0] res_data;
  logic            res_rsvd;

  typedef struct {
    logic [XLEN-1:0] data;
    logic            rsvd;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [XLEN-1:0] last_data = '0;

  always #5 clk = ~clk;

  sbit_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .use_imm(use_imm),
    .src_a(src_a), .src_b(src_b), .imm_sh(imm_sh),
    .res_valid(res_valid), .res_data(res_data), .res_rsvd(res_rsvd)
  );

  // Reference model written bit by bit from the requirements.
  function automatic exp_t model(input logic [1:0] o, input logic ui,
                                 input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                 input logic [5:0] im, input string tag);
    exp_t e;
    int unsigned ix;
    ix = ui ? (int'(im) % XLEN) : (int'(b) % XLEN);
    e.data = a;
    case (o)
      2'b00: e.data[ix] = 1'b0;
      2'b01: e.data[ix] = 1'b1;
      2'b10: e.data[ix] = ~a[ix];
      default: begin
        e.data = '0;
        e.data[0] = a[ix];
      end
    endcase
    e.rsvd = ui && im[5] && (XLEN == 32);
    e.tag = tag;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] got,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [1:0] o, input logic ui, input logic [XLEN-1:0] a,
                      input logic [XLEN-1:0] b, input logic [5:0] im, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op = o; use_imm = ui; src_a = a; src_b = b; imm_sh = im;
    exp_q.push_back(model(o, ui, a, b, im, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    src_a = ~src_a; src_b = ~src_b; imm_sh = ~imm_sh; op = ~op;
  endtask

  // Monitor: a result is due one edge after the drive; sample 2 ns after it.
  always @(posedge clk) begin
    #2;
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected valid", res_data, '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(res_data == e.data, e.tag, res_data, e.data);
        check(res_rsvd == e.rsvd, {e.tag, " R9 flag"}, XLEN'(res_rsvd), XLEN'(e.rsvd));
        last_data = e.data;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R1 valid after reset", XLEN'(res_valid), '0);
    check(res_data == '0, "R1 data after reset", res_data, '0);
    check(res_rsvd == 1'b0, "R1 rsvd after reset", XLEN'(res_rsvd), '0);
    rst = 1'b0;

    send(2'b00, 1'b0, 32'hFFFF_FFFF, 32'd5,         6'h00, "R3 clear bit 5");
    send(2'b00, 1'b0, 32'hFFFF_FFFF, 32'h0000_0025, 6'h3F, "R7 clear upper index ignored");
    send(2'b01, 1'b0, 32'h0,         32'd31,        6'h00, "R4 set top bit");
    send(2'b01, 1'b0, 32'h0,         32'hFFFF_FFE0, 6'h01, "R7 set index wraps to 0");
    send(2'b01, 1'b0, 32'h0000_0100, 32'd8,         6'h00, "R4 set already set");
    send(2'b10, 1'b0, 32'hA5A5_A5A5, 32'd0,         6'h00, "R5 invert bit 0");
    send(2'b10, 1'b0, 32'h0,         32'd16,        6'h00, "R5 invert bit 16");
    send(2'b11, 1'b0, 32'h8000_0000, 32'd31,        6'h00, "R6 extract top one");
    send(2'b11, 1'b0, 32'h7FFF_FFFF, 32'd31,        6'h00, "R6 extract top zero");
    send(2'b11, 1'b0, 32'hFFFF_FFFF, 32'd3,         6'h00, "R6 extract zero-extended");
    send(2'b01, 1'b1, 32'h0,         32'd3,         6'h07, "R8 imm set bit 7");
    send(2'b00, 1'b1, 32'hFFFF_FFFF, 32'd9,         6'h27, "R9 reserved imm clear");
    send(2'b10, 1'b0, 32'h0,         32'd2,         6'h3F, "R9 reg form no flag");
    send(2'b11, 1'b1, 32'h0000_0001, 32'd5,         6'h00, "R8 imm extract bit 0");
    idle();
    idle();
    @(posedge clk); #2;
    check(res_valid == 1'b0, "R2 idle valid low", XLEN'(res_valid), '0);
    check(res_data == last_data, "R10 data held", res_data, last_data);
    check(exp_q.size() == 0, "R2 all results seen", XLEN'(exp_q.size()), '0);
    finish_run();
  end

endmodule